// File: doc/BRIEF.md
# Two-wire debug serial slave

This block is the serial front end of an on-chip debug port. An external master drives a clock line and shares an open-drain data line with it. The block oversamples both lines with the system clock through two-flop synchronizers and turns the serial traffic into bytes. A byte frame opens only after a start condition: the data line falls while the clock line is high. From then on, bytes follow one another with no separator, each nine serial clocks long. Eight clocks carry data, most significant bit first, and the ninth is a slot the core uses for internal work.

For a write byte, the received byte appears on a parallel output with a one-cycle valid strobe. For a read byte, the core raises a read request with the byte to send, and the block shifts that byte onto the data line. It pulls the line low for a zero bit and releases it for a one bit. An enable input gates everything. It stands for the pins being handed to this port rather than to the alternate instrumentation function.

Top module: `dbg2w_slave`

## Requirements
- R1: While en_i is low, the block ignores both lines: sda_oe_o stays low, and neither rx_valid_o nor slot_o pulses, even across a start condition and a full byte. The same holds with a read request pending.
- R2: Before the first start condition after reset or enable, serial clocks and data produce no received byte and no slot pulse.
- R3: A falling data line while the clock line is high opens a byte frame. A rising data line while the clock line is high has no effect: the byte in progress completes with the value sampled at the clock's rising edges.
- R4: Data is sampled on each rising serial clock edge, most significant bit first. After the eighth rising edge of a write byte, rx_data_o carries the byte and rx_valid_o is high for exactly one system clock.
- R5: The ninth rising serial clock of each byte samples no data and raises slot_o for exactly one system clock. Its falling edge begins the next byte without a new start condition.
- R6: If rd_req_i is high at the falling serial clock edge that begins a byte, the block latches tx_data_i and drives it out most significant bit first. For a 0 bit, sda_oe_o is high; for a 1 bit, the line is released. The driven value changes only after a falling serial clock edge, and a read byte raises no rx_valid_o.
- R7: The data line is released (sda_oe_o low) during the ninth serial clock of every byte.
- R8: A start condition in the middle of a byte discards the partial bits and restarts reception at the most significant bit.
- R9: rx_valid_o and slot_o are single-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Port enable; low holds the block idle |
| scl_i | input | 1 | Serial clock line from the master |
| sda_i | input | 1 | Data line as seen at the pad |
| sda_oe_o | output | 1 | Pull the data line low when high |
| rd_req_i | input | 1 | Core requests a read byte at the next byte start |
| tx_data_i | input | 8 | Byte to send in a read byte |
| rx_data_o | output | 8 | Last received write byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| slot_o | output | 1 | One-cycle pulse for the ninth-clock internal slot |

## Verification
The checker watches on every cycle that the outputs stay quiet while disabled. It also checks that the strobe and the slot pulse are single-cycle and never overlap, that a received byte only follows an open frame, and that the drive enable moves only after a falling serial clock or a start. It also checks that the line is released whenever the slot pulse fires. Only the bench scenarios show the values themselves: the bit order of received and sent bytes, and a glitch-free byte across an ignored rising data edge. They also show the discarded partial byte after a mid-byte start, the back-to-back bytes with no new start, and silence before the first start.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic samp;   // data bit sampled on rising serial clock
    logic last;   // sampled bit is the last of the byte
    logic ninth;  // rising edge of the internal-operation clock
    logic load;   // falling edge that opens a byte
    logic drv;    // falling edge that advances the driven bit
    logic rel;    // falling edge entering the ninth clock
    logic start;  // start condition
  } frame_evt_t;
endpackage

// File: rtl/dbg2w_sync.sv
module dbg2w_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,   // at least 2
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= {(STAGES*W){RST_VAL}};
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dbg2w_frame.sv
module dbg2w_frame
  import dbg2w_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        scl_s_i,
  input  logic                        sda_s_i,
  output frame_evt_t                  evt_o,
  output logic                        active_o,
  output logic                        fall_o,
  output logic                        slot_o
);
  localparam int CW = $clog2(BW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(BW - 1);
  localparam logic [CW-1:0] DATA_END = CW'(BW);
  localparam logic [CW-1:0] SLOT_CNT = CW'(BW + 1);

  logic          scl_q, sda_q;
  logic          rise, fall, start, live;
  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign rise  = scl_s_i & ~scl_q;
  assign fall  = ~scl_s_i & scl_q;
  // rising data while clock high is deliberately not decoded
  assign start = en_i & scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign live  = en_i & active & ~start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!en_i) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (rise && cnt <= DATA_END)      cnt <= cnt + 1'b1;
      else if (fall && cnt == SLOT_CNT) cnt <= '0;
    end
  end

  always_comb begin
    evt_o       = '0;
    evt_o.start = start;
    evt_o.samp  = live & rise & (cnt < DATA_END);
    evt_o.last  = live & rise & (cnt == LAST_BIT);
    evt_o.ninth = live & rise & (cnt == DATA_END);
    evt_o.load  = live & fall & ((cnt == '0) | (cnt == SLOT_CNT));
    evt_o.drv   = live & fall & (cnt != '0) & (cnt < DATA_END);
    evt_o.rel   = live & fall & (cnt == DATA_END);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_o <= 1'b0;
    else         slot_o <= evt_o.ninth;
  end

  assign active_o = active;
  assign fall_o   = live & fall;
endmodule

// File: rtl/dbg2w_shift.sv
module dbg2w_shift
  import dbg2w_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  frame_evt_t    evt_i,
  input  logic          sda_s_i,
  input  logic          rd_req_i,
  input  logic [BW-1:0] tx_data_i,
  output logic [BW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          sda_oe_o,
  output logic          rd_mode_o
);
  logic [BW-1:0] rx_sh, tx_sh;
  logic          rd_mode;

  // receive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (evt_i.start) rx_sh <= '0;
      else if (evt_i.samp) rx_sh <= {rx_sh[BW-2:0], sda_s_i};
      if (evt_i.last && !rd_mode) begin
        rx_data_o  <= {rx_sh[BW-2:0], sda_s_i};
        rx_valid_o <= 1'b1;
      end
    end
  end

  // transmit path, open drain: enable low-drive for zero bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh    <= '0;
      rd_mode  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (!en_i || evt_i.start) begin
      rd_mode  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (evt_i.load) begin
      rd_mode  <= rd_req_i;
      tx_sh    <= {tx_data_i[BW-2:0], 1'b0};
      sda_oe_o <= rd_req_i & ~tx_data_i[BW-1];
    end else if (evt_i.drv) begin
      tx_sh    <= {tx_sh[BW-2:0], 1'b0};
      sda_oe_o <= rd_mode & ~tx_sh[BW-1];
    end else if (evt_i.rel) begin
      sda_oe_o <= 1'b0;
    end
  end

  assign rd_mode_o = rd_mode;
endmodule

// File: rtl/dbg2w_slave.sv
module dbg2w_slave
  import dbg2w_pkg::*;
#(
  parameter int BW          = BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          rd_req_i,
  input  logic [BW-1:0] tx_data_i,
  output logic [BW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          slot_o
);
  logic [1:0] lines_s;
  frame_evt_t evt;
  logic       active, scl_fall, rd_mode, start_evt;

  dbg2w_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  dbg2w_frame #(.BW(BW)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .scl_s_i (lines_s[1]),
    .sda_s_i (lines_s[0]),
    .evt_o   (evt),
    .active_o(active),
    .fall_o  (scl_fall),
    .slot_o  (slot_o)
  );

  dbg2w_shift #(.BW(BW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .evt_i     (evt),
    .sda_s_i   (lines_s[0]),
    .rd_req_i  (rd_req_i),
    .tx_data_i (tx_data_i),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .sda_oe_o  (sda_oe_o),
    .rd_mode_o (rd_mode)
  );

  assign start_evt = evt.start;
endmodule

// File: rtl/dbg2w_chk.sv
module dbg2w_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sda_oe_o,
  input logic rx_valid_o,
  input logic slot_o,
  input logic scl_fall,
  input logic start_evt,
  input logic active
);
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sda_oe_o && !rx_valid_o && !slot_o)); // R1

  AST_RX_NEEDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(active)); // R2

  AST_DRIVE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(sda_oe_o)) |-> $past(scl_fall || start_evt)); // R6

  AST_SLOT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> !sda_oe_o); // R7

  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9

  AST_SLOT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |=> !slot_o); // R5

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && slot_o)); // R9
endmodule

bind dbg2w_slave dbg2w_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .sda_oe_o  (sda_oe_o),
  .rx_valid_o(rx_valid_o),
  .slot_o    (slot_o),
  .scl_fall  (scl_fall),
  .start_evt (start_evt),
  .active    (active)
);

// File: tb/dbg2w_slave_tb.sv
module dbg2w_slave_tb;
  localparam int HALF = 8;  // system clocks per serial half period

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       scl_i = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_i;
  logic       sda_oe_o;
  logic       rd_req_i = 1'b0;
  logic [7:0] tx_data_i = 8'h00;
  logic [7:0] rx_data_o;
  logic       rx_valid_o;
  logic       slot_o;

  int checks = 0;
  int fails = 0;
  int slot_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #10 clk_i = ~clk_i;  // 50 MHz

  assign sda_i = m_sda & ~sda_oe_o;  // wired-AND open drain line

  dbg2w_slave u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scl_i(scl_i), .sda_i(sda_i),
    .sda_oe_o(sda_oe_o), .rd_req_i(rd_req_i), .tx_data_i(tx_data_i),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .slot_o(slot_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(posedge clk_i);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected byte", rx_data_o, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data_o == e, "R4 received byte", rx_data_o, e);
      end
    end
    if (rst_ni && slot_o) slot_cnt++;
  end

  // start condition, entered with scl low
  task automatic send_start();
    m_sda = 1'b1; wait_half();
    scl_i = 1'b1; wait_half();
    m_sda = 1'b0; wait_half();
    scl_i = 1'b0; wait_half();
  endtask

  // n data bits, MSB first; glitch_bit gets a rising sda while scl is high
  task automatic send_bits(input logic [7:0] b, input int n, input int glitch_bit);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wait_half();
      scl_i = 1'b1; wait_half();
      if (i == glitch_bit) begin m_sda = 1'b1; wait_half(); end
      scl_i = 1'b0;
    end
  endtask

  task automatic ninth_clk();
    m_sda = 1'b1; wait_half();
    scl_i = 1'b1; wait_half();
    scl_i = 1'b0;
  endtask

  // driver side: push expected item, then clock out the byte
  task automatic write_byte(input logic [7:0] b, input bit expect_rx, input int glitch_bit);
    if (expect_rx) exp_q.push_back(b);
    send_bits(b, 8, glitch_bit);
    ninth_clk();
  endtask

  task automatic read_byte(input logic [7:0] exp, input string req);
    logic [7:0] got;
    bit oe_ninth;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_half();
      scl_i = 1'b1;
      if (i == 7) rd_req_i = 1'b0;
      wait_half();
      got[i] = sda_i;
      scl_i = 1'b0;
    end
    wait_half();
    scl_i = 1'b1; wait_half();
    oe_ninth = sda_oe_o;
    scl_i = 1'b0;
    chk(got == exp, req, got, exp);
    chk(oe_ninth == 1'b0, "R7 line released in ninth clock", oe_ninth, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sda_oe_o == 0 && rx_valid_o == 0 && slot_o == 0, "R1 reset idle",
        {sda_oe_o, rx_valid_o, slot_o}, 0);
    en_i = 1'b1;
    scl_i = 1'b0;
    wait_half();

    // R2: traffic before any start
    write_byte(8'hA5, 1'b0, -1);
    write_byte(8'h0F, 1'b0, -1);
    wait_half();
    chk(slot_cnt == 0, "R2 no slot before start", slot_cnt, 0);

    // R3 R4 R5: start then back-to-back bytes
    send_start();
    write_byte(8'h3C, 1'b1, -1);
    write_byte(8'h81, 1'b1, -1);
    write_byte(8'h00, 1'b1, -1);
    write_byte(8'hFF, 1'b1, -1);
    wait_half();
    chk(slot_cnt == 4, "R5 one slot per byte", slot_cnt, 4);

    // R3: rising sda while scl high on bit 3 (value 0) is ignored
    write_byte(8'h52, 1'b1, 3);
    write_byte(8'hE7, 1'b1, 5);
    wait_half();
    chk(slot_cnt == 6, "R3 rising edge not a stop", slot_cnt, 6);

    // R8: abort after 3 bits, restart at MSB
    send_bits(8'hFF, 3, -1);
    send_start();
    write_byte(8'hC3, 1'b1, -1);
    send_bits(8'h00, 5, -1);
    send_start();
    write_byte(8'h5A, 1'b1, -1);
    wait_half();
    chk(slot_cnt == 8, "R8 aborted bytes give no slot", slot_cnt, 8);

    // R6 R7: reads
    rd_req_i = 1'b1; tx_data_i = 8'h6A;
    send_start();
    read_byte(8'h6A, "R6 read byte 6A");
    rd_req_i = 1'b1; tx_data_i = 8'h95;
    send_start();
    read_byte(8'h95, "R6 read byte 95");
    // a write byte right after a read, no new start
    write_byte(8'h24, 1'b1, -1);
    wait_half();
    chk(slot_cnt == 11, "R5 slot after read bytes", slot_cnt, 11);

    // R1: disabled port ignores start, bytes, read request
    en_i = 1'b0;
    rd_req_i = 1'b1; tx_data_i = 8'h00;
    send_start();
    begin
      bit seen_oe = 0;
      for (int i = 0; i < 8; i++) begin
        send_bits(8'h77, 1, -1);
        if (sda_oe_o) seen_oe = 1;
      end
      ninth_clk();
      wait_half();
      chk(seen_oe == 0, "R1 no drive while disabled", seen_oe, 0);
    end
    chk(slot_cnt == 11, "R1 no slot while disabled", slot_cnt, 11);
    rd_req_i = 1'b0;
    en_i = 1'b1;
    wait_half();

    // R2: after re-enable, bytes ignored until start
    write_byte(8'h99, 1'b0, -1);
    send_start();
    write_byte(8'h18, 1'b1, -1);
    wait_half();
    chk(slot_cnt == 12, "R2 slots only after start", slot_cnt, 12);
    chk(exp_q.size() == 0, "R4 all expected bytes received", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule